// File: doc/BRIEF.md
# Windowed Packet Buffer Access Controller

This block owns a single-port packet memory (2048 bytes by default) and decides, cycle by cycle, which of three users touches it: the host register interface, the transmit datapath or the receive datapath. A two-bit buffer mode input selects the owner. The encoding is 0 = host, 1 = transmit, 2 = receive, 3 = loopback. The host owns the memory only in mode 0. The network side owns it in the other three modes.

The host reaches the memory through a one-byte data window. A 16-bit general pointer (GP) addresses that window and steps by one on every window access, so the host can fill or drain the buffer sequentially. Loading GP first gives random access. A second one-byte window reads a six-byte station identity ROM at the location GP selects, and it leaves GP unchanged. The receive side writes frames from address 0 upward through a 16-bit receive pointer (RP). RP ends holding the frame length in bytes and saturates at the buffer size, so an oversized frame cannot overwrite the buffer. The transmit side streams bytes out from GP up to the end of the buffer.

The receive input and the transmit output are valid/ready byte streams. `rx_ready` is high in modes 2 and 3 and low otherwise. Once RP is saturated, incoming bytes are still accepted and are discarded. The receiver never stalls the sender. `tx_valid` may be high only in modes 1 and 3 while GP is below the buffer size. While `tx_valid` is high and `tx_ready` is low, `tx_data` and GP hold.

Top module: `pktbuf_window_ctrl`

## Requirements
- R1: After reset GP and RP read as zero and `tx_valid` is low.
- R2: A register write to offset 0x8 loads GP bits 7:0 and one to offset 0x9 loads GP bits 15:8. A read at the same offsets returns those bytes.
- R3: In mode 0, a read or write at window offset 0xF reads or writes the memory byte at GP modulo the buffer size, then GP increases by one. Loading GP first gives random access.
- R4: A read at offset 0xC returns station ROM byte GP, where byte 0 is bits 7:0 of the identity parameter, for GP 0 to 5, and returns 0xFF for any larger GP. Such a read never changes GP.
- R5: In modes 2 and 3 `rx_ready` is high. Each accepted byte is written at address RP and RP then increases by one. RP reads at offsets 0xA (bits 7:0) and 0xB (bits 15:8).
- R6: RP stops at the buffer size. Bytes accepted after that point are discarded and leave the memory unchanged.
- R7: Any register write to offset 0xA clears RP to zero.
- R8: In modes 1, 2 and 3 a window read returns 0xFF, a window write is ignored, and GP does not move.
- R9: In modes 1 and 3 `tx_data` is the memory byte at GP and `tx_valid` is high while GP is below the buffer size. `tx_last` marks GP = size - 1. Each handshake advances GP by one, and data and GP hold while `tx_ready` is low.
- R10: In loopback, a cycle with an accepted receive byte uses the single memory port for that write. `tx_valid` is low in that cycle and transmit resumes on the next cycle.
- R11: GP keeps its full 16-bit value. Window accesses wrap modulo the buffer size, and transmit stays idle once GP is at or beyond the buffer size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_mode | input | 2 | Buffer owner: 0 host, 1 transmit, 2 receive, 3 loopback |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of the strobe |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte is the last of the buffer |

## Verification
The bench builds the block with a 64-byte buffer and a fixed six-byte identity. With a buffer that small, RP saturation with overrun bytes, window wrap from GP values several buffer lengths high, and the transmit end marker can all be reached in a few hundred cycles. Random bytes and random transmit stalls are mixed with directed cases at the buffer edges and around the loopback port conflict.

// File: rtl/pba_pkg.sv
`timescale 1ns/1ps
package pba_pkg;
  typedef enum logic [1:0] {
    OWN_HOST = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2,
    OWN_LOOP = 2'd3
  } buf_owner_e;

  localparam logic [3:0] OFS_GP_LO = 4'h8;
  localparam logic [3:0] OFS_GP_HI = 4'h9;
  localparam logic [3:0] OFS_RP_LO = 4'hA;
  localparam logic [3:0] OFS_RP_HI = 4'hB;
  localparam logic [3:0] OFS_ROM   = 4'hC;
  localparam logic [3:0] OFS_WIN   = 4'hF;

  localparam logic [7:0] DENIED_BYTE = 8'hFF;
endpackage

// File: rtl/pba_mem.sv
`timescale 1ns/1ps
module pba_mem #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/pba_rom.sv
`timescale 1ns/1ps
module pba_rom #(
  parameter int ID_BYTES = 6,
  parameter int PTR_W = 16,
  parameter logic [8*ID_BYTES-1:0] STATION_ID = '0,
  localparam int IW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1
) (
  input  logic [PTR_W-1:0] sel,
  output logic [7:0]       byte_o
);
  logic [7:0] id_byte [ID_BYTES];

  for (genvar i = 0; i < ID_BYTES; i++) begin : g_bytes
    assign id_byte[i] = STATION_ID[8*i +: 8];
  end

  always_comb begin
    if (sel < PTR_W'(ID_BYTES)) byte_o = id_byte[sel[IW-1:0]];
    else                        byte_o = 8'hFF;
  end
endmodule

// File: rtl/pba_ptrs.sv
`timescale 1ns/1ps
module pba_ptrs #(
  parameter int DEPTH = 2048,
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gp_lo_we,
  input  logic             gp_hi_we,
  input  logic [7:0]       wbyte,
  input  logic             gp_step,
  input  logic             rp_clr,
  input  logic             rp_step,
  output logic [PTR_W-1:0] gp,
  output logic [PTR_W-1:0] rp,
  output logic             rp_full
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

  assign rp_full = (rp == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gp <= '0;
    end else if (gp_lo_we) begin
      gp[7:0] <= wbyte;
    end else if (gp_hi_we) begin
      gp[PTR_W-1:8] <= wbyte[PTR_W-9:0];
    end else if (gp_step) begin
      gp <= gp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rp <= '0;
    else if (rp_clr)             rp <= '0;
    else if (rp_step && !rp_full) rp <= rp + 1'b1;
  end

  // R6: the receive pointer never passes the buffer size
  a_r6_rp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rp <= LIMIT);

  // R6: a byte arriving at a full pointer leaves it where it is
  a_r6_rp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_step && rp_full && !rp_clr) |=> $stable(rp));

  // R5: each stored byte advances the pointer by one
  a_r5_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_step && !rp_full && !rp_clr) |=> (rp == $past(rp) + 1'b1));

  // R7: a clear lands at zero
  a_r7_rp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rp_clr |=> (rp == '0));
endmodule

// File: rtl/pba_arb.sv
`timescale 1ns/1ps
module pba_arb
  import pba_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  buf_owner_e       owner,
  input  logic             win_rd,
  input  logic             win_wr,
  input  logic             rx_valid,
  input  logic             tx_ready,
  input  logic [PTR_W-1:0] gp,
  input  logic             rp_full,
  output logic             host_own,
  output logic             host_we,
  output logic             rx_ready,
  output logic             rx_take,
  output logic             rx_we,
  output logic             tx_valid,
  output logic             tx_fire,
  output logic             gp_step,
  output logic             use_rp
);
  logic net_rx, net_tx, gp_in_range;

  assign host_own    = (owner == OWN_HOST);
  assign net_rx      = (owner == OWN_RX) || (owner == OWN_LOOP);
  assign net_tx      = (owner == OWN_TX) || (owner == OWN_LOOP);
  assign gp_in_range = (gp < PTR_W'(DEPTH));

  assign rx_ready = net_rx;
  assign rx_take  = rx_valid && net_rx;
  assign rx_we    = rx_take && !rp_full;

  assign tx_valid = net_tx && gp_in_range && !rx_take;
  assign tx_fire  = tx_valid && tx_ready;

  assign host_we  = host_own && win_wr;
  assign gp_step  = tx_fire || (host_own && (win_rd || win_wr));
  assign use_rp   = rx_take;

  // R10: at most one user of the single memory port per cycle
  a_r10_one_port_user: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_we, rx_we, tx_fire}));

  // R10: a receive write in loopback keeps transmit quiet
  a_r10_rx_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |-> !tx_valid);

  // R11: no transmit byte once GP is past the buffer
  a_r11_tx_idle_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (gp >= PTR_W'(DEPTH)) |-> !tx_valid);
endmodule

// File: rtl/pktbuf_window_ctrl.sv
`timescale 1ns/1ps
module pktbuf_window_ctrl
  import pba_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int PTR_W = 16,
  parameter int ID_BYTES = 6,
  parameter logic [8*ID_BYTES-1:0] STATION_ID = 48'h00_00_00_00_00_00,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] buf_mode,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_last
);
  buf_owner_e       owner;
  logic             win_rd, win_wr;
  logic             gp_lo_we, gp_hi_we, rp_clr;
  logic [PTR_W-1:0] gp, rp;
  logic             rp_full;
  logic             host_own, host_we, rx_take, rx_we, tx_fire, gp_step, use_rp;
  logic [AW-1:0]    mem_addr;
  logic             mem_we;
  logic [7:0]       mem_wdata, mem_rdata, rom_byte;

  assign owner    = buf_owner_e'(buf_mode);
  assign win_wr   = reg_wr && (reg_addr == OFS_WIN);
  assign win_rd   = reg_rd && !reg_wr && (reg_addr == OFS_WIN);
  assign gp_lo_we = reg_wr && (reg_addr == OFS_GP_LO);
  assign gp_hi_we = reg_wr && (reg_addr == OFS_GP_HI);
  assign rp_clr   = reg_wr && (reg_addr == OFS_RP_LO);

  pba_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .gp_lo_we(gp_lo_we), .gp_hi_we(gp_hi_we), .wbyte(reg_wdata),
    .gp_step(gp_step), .rp_clr(rp_clr), .rp_step(rx_take),
    .gp(gp), .rp(rp), .rp_full(rp_full)
  );

  pba_arb #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .owner(owner),
    .win_rd(win_rd), .win_wr(win_wr),
    .rx_valid(rx_valid), .tx_ready(tx_ready),
    .gp(gp), .rp_full(rp_full),
    .host_own(host_own), .host_we(host_we),
    .rx_ready(rx_ready), .rx_take(rx_take), .rx_we(rx_we),
    .tx_valid(tx_valid), .tx_fire(tx_fire),
    .gp_step(gp_step), .use_rp(use_rp)
  );

  assign mem_addr  = use_rp ? rp[AW-1:0] : gp[AW-1:0];
  assign mem_we    = rx_we || host_we;
  assign mem_wdata = rx_we ? rx_data : reg_wdata;

  pba_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .addr(mem_addr), .we(mem_we),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  pba_rom #(.ID_BYTES(ID_BYTES), .PTR_W(PTR_W), .STATION_ID(STATION_ID)) u_rom (
    .sel(gp), .byte_o(rom_byte)
  );

  assign tx_data = mem_rdata;
  assign tx_last = tx_valid && (gp == PTR_W'(DEPTH - 1));

  always_comb begin
    unique case (reg_addr)
      OFS_GP_LO: reg_rdata = gp[7:0];
      OFS_GP_HI: reg_rdata = gp[PTR_W-1:8];
      OFS_RP_LO: reg_rdata = rp[7:0];
      OFS_RP_HI: reg_rdata = rp[PTR_W-1:8];
      OFS_ROM:   reg_rdata = rom_byte;
      OFS_WIN:   reg_rdata = host_own ? mem_rdata : DENIED_BYTE;
      default:   reg_rdata = 8'h00;
    endcase
  end

  // R4: the ROM window never moves GP
  a_r4_rom_keeps_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == OFS_ROM) |=> $stable(gp));

  // R8: a window read outside host mode sees the denial byte
  a_r8_denied_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == OFS_WIN && buf_mode != 2'd0)
      |-> (reg_rdata == 8'hFF));

  // R8: window accesses outside host mode leave GP alone
  a_r8_denied_gp: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && reg_addr == OFS_WIN && buf_mode != 2'd0 && !tx_fire)
      |=> $stable(gp));

  // R3: a host window access advances GP by one
  a_r3_window_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && reg_addr == OFS_WIN && buf_mode == 2'd0)
      |=> (gp == $past(gp) + 1'b1));

  // R9: a stalled transmit byte holds its pointer
  a_r9_tx_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !reg_wr && !reg_rd) |=> $stable(gp));
endmodule

// File: tb/pktbuf_window_ctrl_tb.sv
`timescale 1ns/1ps
module pktbuf_window_ctrl_tb;
  localparam int DEPTH = 64;
  localparam logic [47:0] SID = 48'h5F_4E_3D_2C_1B_0A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] buf_mode = 2'd0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       tx_valid, tx_ready = 1'b0, tx_last;
  logic [7:0] tx_data;

  int errs = 0, checks = 0;
  logic [7:0] mm [DEPTH];

  always #2 clk = ~clk;

  pktbuf_window_ctrl #(.DEPTH(DEPTH), .STATION_ID(SID)) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_exp(input int idx);
    return (idx < 6) ? SID[8*idx +: 8] : 8'hFF;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic set_gp(input int v);
    wr(4'h8, v[7:0]); wr(4'h9, v[15:8]);
  endtask

  task automatic get_ptr(input logic [3:0] lo, output int v);
    logic [7:0] a, b;
    rd(lo, a); rd(lo + 4'h1, b); v = {16'h0, b, a};
  endtask

  task automatic push(input logic [7:0] d);
    rx_data = d; rx_valid = 1'b1; #1;
    chk("R5 rx_ready", int'(rx_ready), 1);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    get_ptr(4'h8, v); chk("R1 gp reset", v, 0);
    get_ptr(4'hA, v); chk("R1 rp reset", v, 0);
    chk("R1 tx_valid reset", int'(tx_valid), 0);

    // R2
    set_gp(16'h1234); get_ptr(4'h8, v); chk("R2 gp bytes", v, 16'h1234);
    set_gp(16'hBEEF); get_ptr(4'h8, v); chk("R2 gp bytes", v, 16'hBEEF);

    // R3 sequential fill and drain
    set_gp(5);
    for (int i = 0; i < 20; i++) begin
      b = 8'($urandom); mm[5+i] = b; wr(4'hF, b);
    end
    get_ptr(4'h8, v); chk("R3 gp after fill", v, 25);
    set_gp(5);
    for (int i = 0; i < 20; i++) begin
      rd(4'hF, b); chk("R3 sequential read", b, mm[5+i]);
    end
    // R3 random access
    for (int k = 0; k < 6; k++) begin
      int idx = $urandom_range(5, 24);
      set_gp(idx); rd(4'hF, b); chk("R3 random read", b, mm[idx]);
      get_ptr(4'h8, v); chk("R3 gp step", v, idx + 1);
    end

    // R11 wrap with full pointer kept
    set_gp(DEPTH + 7); rd(4'hF, b); chk("R11 wrap read", b, mm[7]);
    get_ptr(4'h8, v); chk("R11 gp full width", v, DEPTH + 8);
    set_gp(DEPTH * 3 + 30); wr(4'hF, 8'hA5); mm[30] = 8'hA5;
    set_gp(30); rd(4'hF, b); chk("R11 wrap write", b, 8'hA5);

    // R4 ROM window
    for (int i = 0; i < 8; i++) begin
      set_gp(i);
      rd(4'hC, b); chk("R4 rom byte", b, rom_exp(i));
      rd(4'hC, b); chk("R4 rom repeat", b, rom_exp(i));
      get_ptr(4'h8, v); chk("R4 gp unchanged", v, i);
    end

    // R8 denied window in receive mode
    buf_mode = 2'd2;
    set_gp(10);
    rd(4'hF, b); chk("R8 denied read", b, 8'hFF);
    wr(4'hF, 8'h99);
    get_ptr(4'h8, v); chk("R8 gp held", v, 10);
    buf_mode = 2'd0;
    set_gp(10); rd(4'hF, b); chk("R8 write ignored", b, mm[10]);

    // R5 receive a frame
    buf_mode = 2'd2;
    wr(4'hA, 8'h00);
    for (int i = 0; i < 30; i++) begin
      b = 8'($urandom); mm[i] = b; push(b);
    end
    get_ptr(4'hA, v); chk("R5 rp length", v, 30);
    // R7 clear with arbitrary data
    wr(4'hA, 8'h5A); get_ptr(4'hA, v); chk("R7 rp clear", v, 0);
    buf_mode = 2'd0;
    set_gp(0);
    for (int i = 0; i < 30; i++) begin
      rd(4'hF, b); chk("R5 rx stored", b, mm[i]);
    end

    // R6 oversized frame
    buf_mode = 2'd2;
    wr(4'hA, 8'h00);
    for (int i = 0; i < DEPTH + 6; i++) begin
      b = 8'($urandom);
      if (i < DEPTH) mm[i] = b;
      push(b);
    end
    get_ptr(4'hA, v); chk("R6 rp saturated", v, DEPTH);
    buf_mode = 2'd0;
    set_gp(0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'hF, b); chk("R6 no overwrite", b, mm[i]);
    end

    // R9 transmit with random stalls
    set_gp(DEPTH - 5);
    buf_mode = 2'd1;
    for (int k = 0; k < 5; k++) begin
      int s = $urandom_range(0, 2);
      for (int j = 0; j < s; j++) begin
        tx_ready = 1'b0; #1;
        chk("R9 stall valid", int'(tx_valid), 1);
        chk("R9 stall data", tx_data, mm[DEPTH-5+k]);
        @(negedge clk);
      end
      tx_ready = 1'b1; #1;
      chk("R9 tx valid", int'(tx_valid), 1);
      chk("R9 tx data", tx_data, mm[DEPTH-5+k]);
      chk("R9 tx last", int'(tx_last), (k == 4) ? 1 : 0);
      @(negedge clk); tx_ready = 1'b0;
    end
    #1 chk("R11 tx idle at end", int'(tx_valid), 0);
    get_ptr(4'h8, v); chk("R9 gp at end", v, DEPTH);

    // R10 loopback port conflict
    buf_mode = 2'd0;
    set_gp(DEPTH - 3);
    buf_mode = 2'd3;
    wr(4'hA, 8'h00);
    rx_data = 8'h3C; rx_valid = 1'b1; tx_ready = 1'b1; #1;
    chk("R10 tx blocked", int'(tx_valid), 0);
    @(negedge clk); rx_valid = 1'b0; #1;
    chk("R10 tx resumes", int'(tx_valid), 1);
    chk("R10 tx data", tx_data, mm[DEPTH-3]);
    @(negedge clk); tx_ready = 1'b0;
    mm[0] = 8'h3C;
    get_ptr(4'hA, v); chk("R10 rp advanced", v, 1);
    buf_mode = 2'd0;
    set_gp(0); rd(4'hF, b); chk("R10 rx written", b, mm[0]);
    get_ptr(4'h8, v); chk("R10 gp", v, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule